// File: doc/BRIEF.md
# Parallel-Port Wake Signature and Mode Echo Detector

This block sits on a parallel port that several devices share and decides when the host is addressing this adapter. While the SELECT control is asserted, it watches the eight data lines for a four-byte wake signature. The signature is ASCII `b` (0x62), then ASCII `p` (0x70), then a unit number, then the bitwise complement of that unit number. The unit number is compared against an 8-bit strap input.

A byte counts only when the value on the bus changes. A host that finds `b` already sitting on the bus therefore writes a filler byte first. Once the signature is complete, the host releases SELECT and asserts INIT. The next data byte is latched as the transfer mode. Mode bit 2 set means EPP. Other modes use 1 for unidirectional and 3 for bidirectional.

When SELECT comes back, the block echoes the mode on four status lines so the host can confirm it. The echo is plain while AUTOFD is asserted and inverted while AUTOFD is deasserted. Releasing SELECT after the echo marks the adapter as selected. It stays selected until a deselect sequence arrives. For a non-EPP mode that sequence is SELECT asserted and then released. For an EPP mode it is INIT asserted, followed by a SELECT pulse.

All control inputs are taken as already synchronized to `clk` and active-high at the block's pins.

Top module: `pport_wake_detect`

## Requirements
- R1: After reset, `selected_o` is 0, `stat_o` is 0 and `mode_o` is 0x00.
- R2: After the signature 0x62, 0x70, unit, ~unit (each a change on the bus while SELECT is high), then SELECT low with INIT high, the next changed data byte appears on `mode_o` one clock later. While SELECT and AUTOFD are both high afterwards, `stat_o` equals {mode[3], mode[2:0]}.
- R3: In the echo stage with SELECT high and AUTOFD low, `stat_o` equals the bitwise inverse of {mode[3], mode[2:0]}.
- R4: A signature byte counts only when the bus value differs from the previous clock. A 0x62 already present when SELECT rises is not accepted, and a later mode byte is then not latched: `mode_o` keeps its value and `stat_o` stays 0.
- R5: A third byte that differs from `unit_i` returns the detector to idle. No echo or selection follows.
- R6: A wrong second byte (not 0x70) returns the detector to idle.
- R7: SELECT going low before the signature completes returns the detector to idle.
- R8: In the echo stage, SELECT going low sets `selected_o` at the next clock edge.
- R9: With mode bit 2 clear, a selected adapter deselects when SELECT is asserted and then released. `selected_o` stays 1 while SELECT is high and falls on the edge that sees it low.
- R10: With mode bit 2 set, a SELECT pulse alone does not deselect. INIT high followed by a SELECT pulse clears `selected_o` on the release of SELECT.
- R11: `stat_o` is 0 outside the echo stage, including while the adapter is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_i | input | 8 | Parallel data lines |
| sel_i | input | 1 | SELECT control, 1 = asserted |
| afd_i | input | 1 | AUTOFD control, 1 = asserted |
| init_i | input | 1 | INIT control, 1 = asserted |
| unit_i | input | 8 | Strapped unit number |
| stat_o | output | 4 | Status echo: [3] drives status line 7, [2:0] drive lines 5..3 |
| selected_o | output | 1 | Adapter selected, registered |
| mode_o | output | 8 | Latched transfer mode byte |

## Verification
A state that advances on a static level or a wrong byte shows as a non-zero `stat_o` once SELECT and AUTOFD return. The bench probes `stat_o` at exactly that point after every failed signature. A mode register that is not held, or a latch that fires outside the mode stage, shows on `mode_o` at the clock after the offending byte. An exit decoded from the wrong control line shows on `selected_o` at the edge where SELECT is released. The EPP and non-EPP runs each drive the other mode's exit line to expose that case.

// File: rtl/pport_wake_detect.sv
module pport_wake_detect #(
  parameter int DW = 8,
  parameter logic [DW-1:0] SIG0 = 8'h62,
  parameter logic [DW-1:0] SIG1 = 8'h70
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pd_i,
  input  logic          sel_i,
  input  logic          afd_i,
  input  logic          init_i,
  input  logic [DW-1:0] unit_i,
  output logic [3:0]    stat_o,
  output logic          selected_o,
  output logic [DW-1:0] mode_o
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_B, ST_P, ST_U, ST_ARM, ST_MODE, ST_LATCH, ST_ECHO, ST_ON, ST_OFF
  } st_t;

  st_t st, nx;
  logic [DW-1:0] data_q, mode_q;
  logic sel_q, sel_ff;

  wire ev     = pd_i != data_q;
  wire is_epp = mode_q[2];
  wire echo_en = (st == ST_LATCH || st == ST_ECHO) && sel_i;
  wire [3:0] echo = {mode_q[3], mode_q[2:0]};

  assign stat_o     = echo_en ? (afd_i ? echo : ~echo) : 4'b0000;
  assign selected_o = sel_ff;
  assign mode_o     = mode_q;

  always_comb begin
    nx = st;
    unique case (st)
      ST_IDLE:  if (sel_i && ev && pd_i == SIG0) nx = ST_B;
      ST_B:     if (!sel_i) nx = ST_IDLE; else if (ev) nx = (pd_i == SIG1) ? ST_P : ST_IDLE;
      ST_P:     if (!sel_i) nx = ST_IDLE; else if (ev) nx = (pd_i == unit_i) ? ST_U : ST_IDLE;
      ST_U:     if (!sel_i) nx = ST_IDLE; else if (ev) nx = (pd_i == ~unit_i) ? ST_ARM : ST_IDLE;
      ST_ARM:   if (!sel_i && init_i) nx = ST_MODE;
      ST_MODE:  if (sel_i) nx = ST_IDLE; else if (ev) nx = ST_LATCH;
      ST_LATCH: if (sel_i) nx = ST_ECHO;
      ST_ECHO:  if (!sel_i) nx = ST_ON;
      ST_ON:    if (is_epp ? init_i : sel_i) nx = ST_OFF;
      ST_OFF:   if (sel_q && !sel_i) nx = ST_IDLE;
      default:  nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      data_q <= '0;
      mode_q <= '0;
      sel_q  <= 1'b0;
      sel_ff <= 1'b0;
    end else begin
      st     <= nx;
      data_q <= pd_i;
      sel_q  <= sel_i;
      sel_ff <= (nx == ST_ON) || (nx == ST_OFF);
      if (st == ST_MODE && !sel_i && ev) mode_q <= pd_i;
    end
  end

  assert_b_on_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_B && $past(st) == ST_IDLE) |-> ($past(pd_i) != $past(data_q) && $past(pd_i) == SIG0));

  assert_unit_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_U && $past(st) == ST_P) |-> $past(pd_i) == $past(unit_i));

  assert_abort_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_B || st == ST_P || st == ST_U) && !sel_i) |=> st == ST_IDLE);

  assert_enter_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected_o) |-> (!$past(sel_i) && $past(st) == ST_ECHO));

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    selected_o |-> $stable(mode_q));

  assert_quiet_selected_R11: assert property (@(posedge clk) disable iff (!rst_n)
    selected_o |-> stat_o == 4'b0000);

  assert_leave_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(selected_o) |-> ($past(sel_q) && !$past(sel_i)));

endmodule

// File: tb/tb_pport_wake_detect.sv
module tb_pport_wake_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pd = 8'h00, unit = 8'h5A;
  logic sel = 1'b0, afd = 1'b0, init = 1'b0;
  logic [3:0] stat;
  logic selected;
  logic [7:0] mode;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pport_wake_detect dut (
    .clk(clk), .rst_n(rst_n), .pd_i(pd), .sel_i(sel), .afd_i(afd), .init_i(init),
    .unit_i(unit), .stat_o(stat), .selected_o(selected), .mode_o(mode));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic s, input logic a, input logic i);
    @(negedge clk);
    pd = d; sel = s; afd = a; init = i;
    @(posedge clk);
    #1;
  endtask

  task automatic sig(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3);
    put(8'h78, 1, 0, 0);
    put(b0, 1, 0, 0);
    put(b1, 1, 0, 0);
    put(b2, 1, 0, 0);
    put(b3, 1, 0, 0);
  endtask

  task automatic mode_phase(input logic [7:0] m);
    put(pd, 0, 0, 0);
    put(pd, 0, 0, 1);
    put(m, 0, 0, 1);
  endtask

  task automatic t_reset;
    chk("R1 selected", {7'd0, selected}, 8'h00);
    chk("R1 stat", {4'd0, stat}, 8'h00);
    chk("R1 mode", mode, 8'h00);
  endtask

  task automatic t_non_epp;
    sig(8'h62, 8'h70, unit, ~unit);
    mode_phase(8'h03);
    chk("R2 mode latched", mode, 8'h03);
    put(pd, 1, 1, 1);
    chk("R2 echo", {4'd0, stat}, 8'h03);
    put(pd, 1, 0, 1);
    chk("R3 inverse echo", {4'd0, stat}, 8'h0C);
    chk("R8 not yet selected", {7'd0, selected}, 8'h00);
    put(pd, 0, 0, 1);
    chk("R8 selected", {7'd0, selected}, 8'h01);
    chk("R11 quiet after select", {4'd0, stat}, 8'h00);
    put(pd, 1, 1, 1);
    chk("R9 held while SELECT high", {7'd0, selected}, 8'h01);
    chk("R11 quiet while selected", {4'd0, stat}, 8'h00);
    put(pd, 0, 0, 1);
    chk("R9 deselected", {7'd0, selected}, 8'h00);
  endtask

  task automatic t_epp;
    sig(8'h62, 8'h70, unit, ~unit);
    mode_phase(8'h04);
    chk("R2 epp mode", mode, 8'h04);
    put(pd, 1, 1, 1);
    chk("R2 epp echo", {4'd0, stat}, 8'h04);
    put(pd, 1, 0, 1);
    chk("R3 epp inverse", {4'd0, stat}, 8'h0B);
    put(pd, 0, 0, 0);
    chk("R8 epp selected", {7'd0, selected}, 8'h01);
    put(pd, 1, 0, 0);
    put(pd, 0, 0, 0);
    chk("R10 pulse alone keeps select", {7'd0, selected}, 8'h01);
    put(pd, 0, 0, 1);
    put(pd, 1, 0, 1);
    chk("R10 held during pulse", {7'd0, selected}, 8'h01);
    put(pd, 0, 0, 1);
    chk("R10 deselected", {7'd0, selected}, 8'h00);
  endtask

  task automatic t_static_b;
    put(8'h62, 0, 0, 0);
    put(8'h62, 1, 0, 0);
    put(8'h70, 1, 0, 0);
    put(unit, 1, 0, 0);
    put(~unit, 1, 0, 0);
    mode_phase(8'h01);
    chk("R4 mode unchanged", mode, 8'h04);
    put(pd, 1, 1, 1);
    chk("R4 no echo", {4'd0, stat}, 8'h00);
    put(pd, 0, 0, 0);
    chk("R4 not selected", {7'd0, selected}, 8'h00);
  endtask

  task automatic t_bad(input string tag, input logic [7:0] b1, input logic [7:0] b2, input logic drop);
    put(8'h78, 1, 0, 0);
    put(8'h62, 1, 0, 0);
    put(b1, 1, 0, 0);
    if (drop) begin
      put(pd, 0, 0, 0);
      put(pd, 1, 0, 0);
    end
    put(b2, 1, 0, 0);
    put(~b2, 1, 0, 0);
    mode_phase(8'h03);
    chk({tag, " mode unchanged"}, mode, 8'h04);
    put(pd, 1, 1, 1);
    chk({tag, " no echo"}, {4'd0, stat}, 8'h00);
    put(pd, 0, 0, 0);
    chk({tag, " not selected"}, {7'd0, selected}, 8'h00);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_non_epp();
    t_epp();
    t_static_b();
    t_bad("R5", 8'h70, 8'h11, 1'b0);
    t_bad("R6", 8'h71, unit, 1'b0);
    t_bad("R7", 8'h70, unit, 1'b1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule